// File: doc/BRIEF.md
# PCI Power-Management Event Logic

This block carries the power-management event (PME) handshake of a PCI bridge that can sit in a system either as an add-in card (satellite) or as the host. In satellite mode it keeps the two PME bits the host sees in the power-management control/status word: the enable bit and the sticky event status bit. Local software may raise an event. The block then pulls the shared active-low PME# line low through an output-enable, and it tells local software when the host has enabled events or has cleared the status.

In host mode the same block watches the PME# line driven by other devices. It synchronizes the line, catches each new assertion, and latches a detection flag. All local event flags are write-1-to-clear. Each flag has its own interrupt enable, and one interrupt output ORs the enabled flags. The host-side port is a plain write strobe with the two data bits, plus readback outputs. The local side is a small register port with a combinational read. Both are control paths with no stream data, so neither carries a valid/ready handshake.

Top module: `pci_pme_ctrl`

## Requirements
- R1: After reset, the enable and status bits are 0, the PME# output-enable is 0, all local flags are 0, the interrupt enables are 0 and the interrupt output is 0.
- R2: In satellite mode, a host write with the enable data bit at 1 while enable is 0 sets enable and sets local flag bit 0 (enable-set). The enable value reads at local address 3 bit 0 and on `pmcsr_en_o`.
- R3: In satellite mode with enable at 1, a local write to address 0 with data bit 0 at 1 sets the status bit at that edge. From the next cycle, `pme_oe_o` is 1, meaning the open-drain line is pulled low.
- R4: A local write to address 0 with bit 0 at 0, or any such write while enable is 0, changes neither the status bit nor `pme_oe_o`.
- R5: A host write with the status data bit at 1 clears a set status bit, releases `pme_oe_o` and sets local flag bit 1 (status-cleared). A host write while status is already 0 sets no flag, and a host write with the status data bit at 0 leaves status unchanged. If a host clear and a local raise arrive in the same cycle, the clear wins.
- R6: A host write that clears enable while status is 1 leaves status at 1 and releases `pme_oe_o`. Setting enable again pulls the line low once more.
- R7: In host mode, a falling edge on `pme_n_i`, seen through a two-flop synchronizer, sets local flag bit 2 (detected) three clock edges after the line falls. A line held low sets the flag only once per assertion, so a flag cleared while the line stays low remains clear.
- R8: In host mode, `pme_oe_o` is 0 at all times, and host writes and local raise commands change neither the enable bit nor the status bit.
- R9: A local write to address 1 clears every flag whose data bit is 1 and leaves the others unchanged. A flag set in the same cycle stays set.
- R10: Local address 2 bits [2:0] hold the interrupt enables, and `irq_o` equals the OR of flags ANDed with those enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_mode_i | input | 1 | 1 = host behaviour, 0 = satellite behaviour |
| cfg_we_i | input | 1 | Host write strobe to the PM control/status word |
| cfg_en_wd_i | input | 1 | Host write data: PME enable |
| cfg_sts_wd_i | input | 1 | Host write data: 1 clears PME status |
| pmcsr_en_o | output | 1 | PME enable as seen by the host |
| pmcsr_sts_o | output | 1 | PME status as seen by the host |
| loc_we_i | input | 1 | Local register write strobe |
| loc_addr_i | input | 2 | Local register address |
| loc_wdata_i | input | 8 | Local write data |
| loc_rdata_o | output | 8 | Local read data (combinational) |
| pme_n_i | input | 1 | PME# pad input |
| pme_oe_o | output | 1 | 1 = pull PME# low, 0 = release |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest situation to reach is a status bit left set with the line released, which R6 describes. The host has to clear enable after an event is raised and then set it again. The stimulus table orders host and local writes so that the bench passes through it and checks each step. The other hard case is the held-low detection line in host mode: the bench clears the detect flag while the pad stays low, waits several cycles to confirm the flag does not return, then releases the pad and pulls it low again.

// File: rtl/pme_pkg.sv
package pme_pkg;
  localparam int NFLAG = 3;
  localparam int FLG_EN_SET  = 0;
  localparam int FLG_STS_CLR = 1;
  localparam int FLG_DETECT  = 2;
  localparam logic [1:0] A_CMD    = 2'd0;
  localparam logic [1:0] A_FLAGS  = 2'd1;
  localparam logic [1:0] A_IEN    = 2'd2;
  localparam logic [1:0] A_STATUS = 2'd3;
endpackage

// File: rtl/pme_sync_fall.sv
module pme_sync_fall #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic pad_n_i,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      last_q <= 1'b1;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], pad_n_i};
      last_q <= sh_q[STAGES-1];
    end
  end

  assign fall_o = en_i & last_q & ~sh_q[STAGES-1];

  // R7
  once_per_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/pme_sat_core.sv
module pme_sat_core (
  input  logic clk,
  input  logic rst_n,
  input  logic sat_i,
  input  logic cfg_we_i,
  input  logic cfg_en_wd_i,
  input  logic cfg_sts_wd_i,
  input  logic raise_i,
  output logic en_o,
  output logic sts_o,
  output logic en_set_evt_o,
  output logic sts_clr_evt_o
);
  logic en_q, sts_q, host_wr, do_set;

  assign host_wr       = sat_i & cfg_we_i;
  assign en_set_evt_o  = host_wr & cfg_en_wd_i & ~en_q;
  assign sts_clr_evt_o = host_wr & cfg_sts_wd_i & sts_q;
  assign do_set        = sat_i & raise_i & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sts_q <= 1'b0;
    end else begin
      if (host_wr) en_q <= cfg_en_wd_i;
      if (sts_clr_evt_o)  sts_q <= 1'b0;
      else if (do_set)    sts_q <= 1'b1;
    end
  end

  assign en_o  = en_q;
  assign sts_o = sts_q;

  // R3
  sts_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q) |-> $past(raise_i && en_q && sat_i));
  // R6
  sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q && !(cfg_we_i && cfg_sts_wd_i)) |=> sts_q);
  // R8
  host_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sat_i |=> ($stable(en_q) && $stable(sts_q)));
endmodule

// File: rtl/pme_flags.sv
module pme_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         ien_we_i,
  input  logic [N-1:0] ien_wd_i,
  output logic [N-1:0] flags_o,
  output logic [N-1:0] ien_o,
  output logic         irq_o
);
  logic [N-1:0] flg_q, ien_q;

  for (genvar k = 0; k < N; k++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flg_q[k] <= 1'b0;
      else if (set_i[k]) flg_q[k] <= 1'b1;
      else if (clr_i[k]) flg_q[k] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ien_q <= '0;
    else if (ien_we_i) ien_q <= ien_wd_i;
  end

  assign flags_o = flg_q;
  assign ien_o   = ien_q;
  assign irq_o   = |(flg_q & ien_q);

  // R9
  set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flg_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/pci_pme_ctrl.sv
module pci_pme_ctrl #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_mode_i,
  input  logic          cfg_we_i,
  input  logic          cfg_en_wd_i,
  input  logic          cfg_sts_wd_i,
  output logic          pmcsr_en_o,
  output logic          pmcsr_sts_o,
  input  logic          loc_we_i,
  input  logic [1:0]    loc_addr_i,
  input  logic [DW-1:0] loc_wdata_i,
  output logic [DW-1:0] loc_rdata_o,
  input  logic          pme_n_i,
  output logic          pme_oe_o,
  output logic          irq_o
);
  import pme_pkg::*;
  localparam int PAD = DW - NFLAG;

  logic en, sts, en_evt, clr_evt, det_evt, raise;
  logic [NFLAG-1:0] set_v, clr_v, flags, ien;

  assign raise = loc_we_i && (loc_addr_i == A_CMD) && loc_wdata_i[0];

  pme_sat_core u_sat (
    .clk(clk), .rst_n(rst_n), .sat_i(!host_mode_i),
    .cfg_we_i(cfg_we_i), .cfg_en_wd_i(cfg_en_wd_i), .cfg_sts_wd_i(cfg_sts_wd_i),
    .raise_i(raise), .en_o(en), .sts_o(sts),
    .en_set_evt_o(en_evt), .sts_clr_evt_o(clr_evt)
  );

  pme_sync_fall #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .en_i(host_mode_i),
    .pad_n_i(pme_n_i), .fall_o(det_evt)
  );

  always_comb begin
    set_v = '0;
    set_v[FLG_EN_SET]  = en_evt;
    set_v[FLG_STS_CLR] = clr_evt;
    set_v[FLG_DETECT]  = det_evt;
  end

  assign clr_v = (loc_we_i && loc_addr_i == A_FLAGS) ? loc_wdata_i[NFLAG-1:0] : '0;

  pme_flags #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(clr_v),
    .ien_we_i(loc_we_i && loc_addr_i == A_IEN), .ien_wd_i(loc_wdata_i[NFLAG-1:0]),
    .flags_o(flags), .ien_o(ien), .irq_o(irq_o)
  );

  always_comb begin
    case (loc_addr_i)
      A_FLAGS:  loc_rdata_o = {{PAD{1'b0}}, flags};
      A_IEN:    loc_rdata_o = {{PAD{1'b0}}, ien};
      A_STATUS: loc_rdata_o = {{(DW-2){1'b0}}, sts, en};
      default:  loc_rdata_o = '0;
    endcase
  end

  assign pmcsr_en_o  = en;
  assign pmcsr_sts_o = sts;
  assign pme_oe_o    = !host_mode_i && en && sts;

  // R8
  host_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_mode_i |-> !pme_oe_o);
  // R5
  clr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pmcsr_sts_o) |-> flags[FLG_STS_CLR]);
endmodule

// File: tb/tb_pci_pme_ctrl.sv
module tb_pci_pme_ctrl;
  logic clk = 0, rst_n = 0, host_mode = 0;
  logic cfg_we = 0, cfg_en = 0, cfg_sts = 0;
  logic pm_en, pm_sts;
  logic lwe = 0;
  logic [1:0] laddr = 0;
  logic [7:0] lwd = 0, lrd;
  logic pad_n = 1, oe, irq;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  pci_pme_ctrl dut (
    .clk(clk), .rst_n(rst_n), .host_mode_i(host_mode),
    .cfg_we_i(cfg_we), .cfg_en_wd_i(cfg_en), .cfg_sts_wd_i(cfg_sts),
    .pmcsr_en_o(pm_en), .pmcsr_sts_o(pm_sts),
    .loc_we_i(lwe), .loc_addr_i(laddr), .loc_wdata_i(lwd), .loc_rdata_o(lrd),
    .pme_n_i(pad_n), .pme_oe_o(oe), .irq_o(irq)
  );

  // op: 0 host write (d[0]=enable, d[1]=status clear), 1 local write
  typedef struct packed {
    logic       op;
    logic [1:0] a;
    logic [7:0] d;
    logic       e_en, e_sts, e_oe;
    logic [2:0] e_flg;
  } vec_t;

  localparam vec_t VT [11] = '{
    '{1'b1, 2'd0, 8'h01, 1'b0, 1'b0, 1'b0, 3'b000}, // R4 raise while disabled
    '{1'b0, 2'd0, 8'h01, 1'b1, 1'b0, 1'b0, 3'b001}, // R2 enable set
    '{1'b1, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0, 3'b001}, // R4 write 0
    '{1'b1, 2'd0, 8'h01, 1'b1, 1'b1, 1'b1, 3'b001}, // R3 raise
    '{1'b0, 2'd0, 8'h01, 1'b1, 1'b1, 1'b1, 3'b001}, // R5 sts data 0
    '{1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0, 3'b001}, // R6 enable cleared
    '{1'b0, 2'd0, 8'h01, 1'b1, 1'b1, 1'b1, 3'b001}, // R6 enable again
    '{1'b1, 2'd1, 8'h01, 1'b1, 1'b1, 1'b1, 3'b000}, // R9 w1c bit0
    '{1'b0, 2'd0, 8'h03, 1'b1, 1'b0, 1'b0, 3'b010}, // R5 host clear
    '{1'b0, 2'd0, 8'h03, 1'b1, 1'b0, 1'b0, 3'b010}, // R5 clear when 0
    '{1'b1, 2'd1, 8'h02, 1'b1, 1'b0, 1'b0, 3'b000}  // R9 w1c bit1
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic e, input logic s);
    @(negedge clk); cfg_we = 1; cfg_en = e; cfg_sts = s;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic loc_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); lwe = 1; laddr = a; lwd = d;
    @(negedge clk); lwe = 0;
  endtask

  task automatic rd_flags(output logic [7:0] v);
    laddr = 2'd1; #1 v = lrd;
  endtask

  logic [7:0] rv;

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 en", pm_en, 0); chk("R1 sts", pm_sts, 0); chk("R1 oe", oe, 0);
    chk("R1 irq", irq, 0); rd_flags(rv); chk("R1 flags", rv, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 11; i++) begin
      if (VT[i].op) loc_wr(VT[i].a, VT[i].d);
      else host_wr(VT[i].d[0], VT[i].d[1]);
      chk($sformatf("vec%0d en", i), pm_en, VT[i].e_en);
      chk($sformatf("vec%0d sts", i), pm_sts, VT[i].e_sts);
      chk($sformatf("vec%0d oe", i), oe, VT[i].e_oe);
      rd_flags(rv);
      chk($sformatf("vec%0d flags", i), rv, {5'b0, VT[i].e_flg});
    end

    // R2 enable readable locally
    laddr = 2'd3; #1 chk("R2 status reg", lrd, 8'h01);

    // R10 interrupt combine
    loc_wr(2'd2, 8'h01);
    laddr = 2'd2; #1 chk("R10 ien readback", lrd, 8'h01);
    chk("R10 irq idle", irq, 0);
    host_wr(0, 0); host_wr(1, 0);
    chk("R10 irq on", irq, 1);
    loc_wr(2'd2, 8'h06);
    chk("R10 irq masked", irq, 0);
    loc_wr(2'd1, 8'h07);

    // R8 host mode: no drive, writes ignored
    host_mode = 1;
    loc_wr(2'd0, 8'h01);
    chk("R8 sts unchanged", pm_sts, 0);
    host_wr(0, 0);
    chk("R8 en unchanged", pm_en, 1);
    chk("R8 oe", oe, 0);

    // R7 detection
    @(negedge clk); pad_n = 0;
    @(negedge clk); rd_flags(rv); chk("R7 not yet", rv[2], 0);
    @(negedge clk); @(negedge clk);
    rd_flags(rv); chk("R7 detect", rv[2], 1);
    chk("R7 irq", irq, 1);
    chk("R8 oe while low", oe, 0);
    loc_wr(2'd1, 8'h04);
    repeat (5) @(negedge clk);
    rd_flags(rv); chk("R7 held low once", rv[2], 0);
    pad_n = 1;
    repeat (4) @(negedge clk);
    pad_n = 0;
    repeat (4) @(negedge clk);
    rd_flags(rv); chk("R7 second edge", rv[2], 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule